// File: doc/BRIEF.md
# Bank-Mapped Configuration Register Unit

This unit keeps the 16-bit configuration word of a two-bank memory device. The word has no address in the memory map. It is written and read only through commands. An upstream command decoder has already recognised the unlock sequences and hands this unit single-cycle pulses. Each pulse carries a bank number.

A configuration-read command does not return data itself. It records the bank it was issued with. After that, every array read aimed at the recorded bank returns the configuration word on the low half of the data bus, with zeros on the upper half. Reads to any other bank keep returning the array data that arrives on the input bus. A reset command pulse, or a hardware reset, removes this redirection.

A configuration write is accepted only while no embedded program or erase is running. The stored word is also driven continuously to neighbouring logic, both as the full word and as decoded latency and burst-enable fields.

Top module: `cfg_reg_unit`

## Requirements
- R1: After hardware reset the word reads 0x0003. The latency code in bits [3:0] is 3, the burst-enable bit 15 is 0, no bank is redirected, and `rd_word` is 0.
- R2: A write pulse while `emb_busy` is low loads `cfg_wr_data` into `cfg_bits` on the next cycle, whichever bank number comes with it.
- R3: A write pulse while `emb_busy` is high is dropped, and `cfg_bits` keeps its prior value.
- R4: `cfg_bits` changes only through an accepted write. Toggling `chip_en` and issuing reads or commands leave it unchanged.
- R5: After a configuration-read command on bank B, a read of bank B with `chip_en` high returns {16'h0000, cfg_bits} on `rd_word` one cycle after `rd_en`.
- R6: With no redirection active, or for a read of a bank other than the recorded one, `rd_word` returns that bank's array word (slice `rd_bank`*32 of `arr_rd_data`) one cycle after `rd_en`.
- R7: A reset command pulse clears the redirection, so both banks return array data. If it arrives in the same cycle as a configuration-read command, the reset wins.
- R8: A read issued while `chip_en` is low leaves `rd_word` unchanged.
- R9: `lat_code` always equals `cfg_bits[3:0]`, and `burst_en` always equals `cfg_bits[15]`.
- R10: A later configuration-read command on a different bank moves the redirection to that bank, and the first bank returns array data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low hardware reset |
| chip_en | input | 1 | device select; gates reads only |
| cfg_rd_cmd | input | 1 | configuration-read command pulse |
| cfg_wr_cmd | input | 1 | configuration-write command pulse |
| cmd_reset | input | 1 | reset command pulse, clears redirection |
| cmd_bank | input | 1 | bank number carried with a command pulse |
| cfg_wr_data | input | 16 | new configuration word |
| emb_busy | input | 1 | embedded program/erase in progress |
| rd_en | input | 1 | array read request |
| rd_bank | input | 1 | bank of the read request |
| arr_rd_data | input | 64 | array read words, bank 0 in the low 32 bits |
| rd_word | output | 32 | registered read result |
| cfg_bits | output | 16 | current configuration word |
| lat_code | output | 4 | latency field |
| burst_en | output | 1 | burst mode enable |

## Verification
The assertions take the command inputs to be one-cycle pulses sampled on the rising edge. They also take `arr_rd_data` to be valid in the same cycle as `rd_en`. Only the cycle after a read or write is checked against the values seen at that edge.

The bench drives every input one time unit after a rising edge and holds it for exactly one cycle, so each pulse is single-cycle. It sets the array words together with the read request. It also keeps `rd_bank` and `cmd_bank` inside the two existing banks.

// File: rtl/cfgu_pkg.sv
package cfgu_pkg;
   // Source selected for the registered read word
   typedef enum logic [1:0] {
      SRC_HOLD  = 2'd0,
      SRC_ARRAY = 2'd1,
      SRC_CFG   = 2'd2
   } rd_src_e;

   // Places a latency code into an otherwise zero configuration word
   function automatic logic [31:0] place_field(input int unsigned code,
                                               input int unsigned lsb);
      logic [31:0] w;
      w = 32'(code) << lsb;
      return w;
   endfunction
endpackage

// File: rtl/cfgu_store.sv
module cfgu_store #(
   parameter int unsigned          CFG_W     = 16,
   parameter logic [CFG_W-1:0]     RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic             busy,
   input  logic [CFG_W-1:0] wr_data,
   output logic [CFG_W-1:0] cfg_q
);
   logic accept;

   // A write during an embedded operation is discarded
   assign accept = wr_req & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= RESET_VAL;
      else if (accept) cfg_q <= wr_data;
   end
endmodule

// File: rtl/cfgu_override.sv
module cfgu_override #(
   parameter int unsigned BANK_W = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_rd,
   input  logic              cmd_rst,
   input  logic [BANK_W-1:0] cmd_bank,
   output logic              active,
   output logic [BANK_W-1:0] bank
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         bank   <= '0;
      end else if (cmd_rst) begin
         // reset command takes priority over a simultaneous config read
         active <= 1'b0;
      end else if (cfg_rd) begin
         active <= 1'b1;
         bank   <= cmd_bank;
      end
   end
endmodule

// File: rtl/cfgu_rdpath.sv
module cfgu_rdpath
   import cfgu_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CFG_W     = 16,
   parameter int unsigned BANK_W    = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rd_en,
   input  logic                        chip_en,
   input  logic [BANK_W-1:0]           rd_bank,
   input  logic [NUM_BANKS*DATA_W-1:0] arr_data,
   input  logic [CFG_W-1:0]            cfg_q,
   input  logic                        ovr_active,
   input  logic [BANK_W-1:0]           ovr_bank,
   output logic [DATA_W-1:0]           rd_word
);
   localparam int unsigned PAD_W = DATA_W - CFG_W;

   logic [DATA_W-1:0] bank_word [NUM_BANKS];
   logic [DATA_W-1:0] arr_sel;
   logic [DATA_W-1:0] cfg_word;
   rd_src_e           src;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
      assign bank_word[b] = arr_data[b*DATA_W +: DATA_W];
   end

   if (PAD_W == 0) begin : g_nopad
      assign cfg_word = cfg_q;
   end else begin : g_pad
      assign cfg_word = {{PAD_W{1'b0}}, cfg_q};
   end

   always_comb begin
      arr_sel = '0;
      for (int b = 0; b < NUM_BANKS; b++)
         if (rd_bank == BANK_W'(b)) arr_sel = bank_word[b];
   end

   always_comb begin
      if (!(rd_en && chip_en))                 src = SRC_HOLD;
      else if (ovr_active && rd_bank == ovr_bank) src = SRC_CFG;
      else                                     src = SRC_ARRAY;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_word <= '0;
      else begin
         unique case (src)
            SRC_CFG:   rd_word <= cfg_word;
            SRC_ARRAY: rd_word <= arr_sel;
            default:   rd_word <= rd_word;
         endcase
      end
   end
endmodule

// File: rtl/cfg_reg_unit.sv
module cfg_reg_unit
   import cfgu_pkg::*;
#(
   parameter int unsigned NUM_BANKS   = 2,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CFG_W       = 16,
   parameter int unsigned LAT_LSB     = 0,
   parameter int unsigned LAT_W       = 4,
   parameter int unsigned LAT_DEFAULT = 3,
   parameter int unsigned BURST_BIT   = 15,
   localparam int unsigned BANK_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        chip_en,
   input  logic                        cfg_rd_cmd,
   input  logic                        cfg_wr_cmd,
   input  logic                        cmd_reset,
   input  logic [BANK_W-1:0]           cmd_bank,
   input  logic [CFG_W-1:0]            cfg_wr_data,
   input  logic                        emb_busy,
   input  logic                        rd_en,
   input  logic [BANK_W-1:0]           rd_bank,
   input  logic [NUM_BANKS*DATA_W-1:0] arr_rd_data,
   output logic [DATA_W-1:0]           rd_word,
   output logic [CFG_W-1:0]            cfg_bits,
   output logic [LAT_W-1:0]            lat_code,
   output logic                        burst_en
);
   localparam logic [CFG_W-1:0] CFG_RESET = CFG_W'(place_field(LAT_DEFAULT, LAT_LSB));

   // elaboration-time parameter checks
   if (NUM_BANKS < 2)                 begin : g_chk_banks $error("NUM_BANKS must be at least 2"); end
   if (CFG_W > DATA_W)                begin : g_chk_width $error("CFG_W exceeds DATA_W"); end
   if (LAT_LSB + LAT_W > CFG_W)       begin : g_chk_lat   $error("latency field outside word"); end
   if (BURST_BIT >= CFG_W)            begin : g_chk_burst $error("burst bit outside word"); end
   if (LAT_DEFAULT >= (1 << LAT_W))   begin : g_chk_ldef  $error("latency default too wide"); end
   if (BURST_BIT >= LAT_LSB && BURST_BIT < LAT_LSB + LAT_W)
                                      begin : g_chk_ovl   $error("burst bit overlaps latency"); end

   logic              ovr_active;
   logic [BANK_W-1:0] ovr_bank;

   cfgu_store #(.CFG_W(CFG_W), .RESET_VAL(CFG_RESET)) i_store (
      .clk(clk), .rst_n(rst_n), .wr_req(cfg_wr_cmd), .busy(emb_busy),
      .wr_data(cfg_wr_data), .cfg_q(cfg_bits));

   cfgu_override #(.BANK_W(BANK_W)) i_ovr (
      .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd_cmd), .cmd_rst(cmd_reset),
      .cmd_bank(cmd_bank), .active(ovr_active), .bank(ovr_bank));

   cfgu_rdpath #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .CFG_W(CFG_W),
                 .BANK_W(BANK_W)) i_rd (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .chip_en(chip_en),
      .rd_bank(rd_bank), .arr_data(arr_rd_data), .cfg_q(cfg_bits),
      .ovr_active(ovr_active), .ovr_bank(ovr_bank), .rd_word(rd_word));

   assign lat_code = cfg_bits[LAT_LSB +: LAT_W];
   assign burst_en = cfg_bits[BURST_BIT];
endmodule

// File: rtl/cfgu_checker.sv
module cfgu_checker #(
   parameter int unsigned NUM_BANKS = 2,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned CFG_W     = 16,
   parameter int unsigned BANK_W    = 1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        chip_en,
   input logic                        cfg_rd_cmd,
   input logic                        cfg_wr_cmd,
   input logic                        cmd_reset,
   input logic [BANK_W-1:0]           cmd_bank,
   input logic [CFG_W-1:0]            cfg_wr_data,
   input logic                        emb_busy,
   input logic                        rd_en,
   input logic [BANK_W-1:0]           rd_bank,
   input logic [NUM_BANKS*DATA_W-1:0] arr_rd_data,
   input logic [DATA_W-1:0]           rd_word,
   input logic [CFG_W-1:0]            cfg_bits,
   input logic                        ovr_active,
   input logic [BANK_W-1:0]           ovr_bank
);
   a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_cmd && !emb_busy |=> cfg_bits == $past(cfg_wr_data));

   a_r3_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_cmd && emb_busy |=> $stable(cfg_bits));

   a_r4_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr_cmd |=> $stable(cfg_bits));

   a_r5_cfg_on_latched_bank: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && chip_en && ovr_active && rd_bank == ovr_bank
      |=> rd_word == DATA_W'($past(cfg_bits)));

   a_r6_array_elsewhere: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && chip_en && !(ovr_active && rd_bank == ovr_bank)
      |=> rd_word == $past(arr_rd_data[rd_bank*DATA_W +: DATA_W]));

   a_r7_reset_cmd_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_reset |=> !ovr_active);

   a_r8_deselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en && chip_en) |=> $stable(rd_word));

   a_r10_bank_latched: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rd_cmd && !cmd_reset |=> ovr_active && ovr_bank == $past(cmd_bank));
endmodule

bind cfg_reg_unit cfgu_checker #(
   .NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W), .CFG_W(CFG_W), .BANK_W(BANK_W)
) i_cfgu_checker (
   .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_rd_cmd(cfg_rd_cmd),
   .cfg_wr_cmd(cfg_wr_cmd), .cmd_reset(cmd_reset), .cmd_bank(cmd_bank),
   .cfg_wr_data(cfg_wr_data), .emb_busy(emb_busy), .rd_en(rd_en),
   .rd_bank(rd_bank), .arr_rd_data(arr_rd_data), .rd_word(rd_word),
   .cfg_bits(cfg_bits), .ovr_active(ovr_active), .ovr_bank(ovr_bank));

// File: tb/test_cfg_reg_unit.sv
module test_cfg_reg_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chip_en = 1'b1;
   logic        cfg_rd_cmd = 1'b0, cfg_wr_cmd = 1'b0, cmd_reset = 1'b0;
   logic [0:0]  cmd_bank = '0, rd_bank = '0;
   logic [15:0] cfg_wr_data = '0;
   logic        emb_busy = 1'b0, rd_en = 1'b0;
   logic [63:0] arr_rd_data = '0;
   logic [31:0] rd_word;
   logic [15:0] cfg_bits;
   logic [3:0]  lat_code;
   logic        burst_en;

   int n_cmp = 0, n_bad = 0, seq = 0;
   logic [15:0] m_cfg;
   logic        m_act;
   logic        m_bank;
   logic [31:0] m_rd;

   always #2 clk = ~clk;

   cfg_reg_unit i_cfg_reg_unit (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .cfg_rd_cmd(cfg_rd_cmd),
      .cfg_wr_cmd(cfg_wr_cmd), .cmd_reset(cmd_reset), .cmd_bank(cmd_bank),
      .cfg_wr_data(cfg_wr_data), .emb_busy(emb_busy), .rd_en(rd_en),
      .rd_bank(rd_bank), .arr_rd_data(arr_rd_data), .rd_word(rd_word),
      .cfg_bits(cfg_bits), .lat_code(lat_code), .burst_en(burst_en));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic check_fields();
      check("R9 lat", 32'(lat_code), 32'(m_cfg[3:0]));
      check("R9 burst", 32'(burst_en), 32'(m_cfg[15]));
   endtask

   task automatic do_write(logic [15:0] v, logic b, logic bsy);
      cfg_wr_cmd = 1'b1; cfg_wr_data = v; cmd_bank = b; emb_busy = bsy;
      step();
      cfg_wr_cmd = 1'b0; emb_busy = 1'b0;
      if (!bsy) m_cfg = v;
      check(bsy ? "R3 busy write" : "R2 write", 32'(cfg_bits), 32'(m_cfg));
      check_fields();
   endtask

   task automatic do_read(logic b, logic ce);
      seq++;
      arr_rd_data = {32'hB1B1_0000 | 32'(seq), 32'hA0A0_0000 | 32'(seq)};
      rd_en = 1'b1; rd_bank = b; chip_en = ce;
      step();
      if (ce) m_rd = (m_act && m_bank == b) ? {16'h0, m_cfg} : arr_rd_data[b*32 +: 32];
      rd_en = 1'b0; chip_en = 1'b1;
      if (!ce)                      check("R8 deselected", rd_word, m_rd);
      else if (m_act && m_bank == b) check("R5 cfg read", rd_word, m_rd);
      else                          check("R6 array read", rd_word, m_rd);
      check("R4 cfg unchanged by read", 32'(cfg_bits), 32'(m_cfg));
   endtask

   task automatic cfg_read_cmd(logic b, logic rst_too);
      cfg_rd_cmd = 1'b1; cmd_bank = b; cmd_reset = rst_too;
      step();
      cfg_rd_cmd = 1'b0; cmd_reset = 1'b0;
      if (rst_too) m_act = 1'b0;
      else begin m_act = 1'b1; m_bank = b; end
   endtask

   task automatic reset_cmd();
      cmd_reset = 1'b1;
      step();
      cmd_reset = 1'b0;
      m_act = 1'b0;
   endtask

   task automatic sweep_reads();
      for (int b = 0; b < 2; b++)
         for (int ce = 1; ce >= 0; ce--)
            do_read(b[0], ce[0]);
   endtask

   initial begin
      #2000000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      m_cfg = 16'h0003; m_act = 1'b0; m_bank = 1'b0; m_rd = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check("R1 reset cfg", 32'(cfg_bits), 32'h0003);
      check("R1 reset rd_word", rd_word, 32'h0);
      check("R1 reset lat", 32'(lat_code), 32'd3);
      check("R1 reset burst", 32'(burst_en), 32'd0);
      rst_n = 1'b1;
      step();
      // R1: no redirection after reset, both banks give array data
      sweep_reads();

      // R2/R3 sweep of values, busy and bank
      for (int i = 0; i < 16; i++)
         for (int bsy = 0; bsy < 2; bsy++)
            for (int b = 0; b < 2; b++)
               do_write(16'(i * 16'h1111) ^ 16'(bsy * 16'h8421 + b * 16'h0F0F),
                        b[0], bsy[0]);

      // R4: chip enable toggling leaves the word alone
      for (int k = 0; k < 4; k++) begin
         chip_en = k[0];
         step();
         check("R4 chip_en toggle", 32'(cfg_bits), 32'(m_cfg));
      end
      chip_en = 1'b1;

      // R5/R6/R10 all override banks with all read banks
      for (int ob = 0; ob < 2; ob++) begin
         cfg_read_cmd(ob[0], 1'b0);
         sweep_reads();
         do_write(16'hC005 ^ 16'(ob), 1'b1, 1'b0);
         do_read(ob[0], 1'b1);
         do_write(16'hFFFF, ob[0], 1'b1);
         do_read(ob[0], 1'b1);
      end
      // R10 retarget
      cfg_read_cmd(1'b0, 1'b0);
      do_read(1'b0, 1'b1);
      cfg_read_cmd(1'b1, 1'b0);
      do_read(1'b0, 1'b1);
      do_read(1'b1, 1'b1);

      // R7 reset command clears, and wins over simultaneous config read
      reset_cmd();
      sweep_reads();
      cfg_read_cmd(1'b1, 1'b0);
      cfg_read_cmd(1'b0, 1'b1);
      sweep_reads();
      check("R4 cfg after commands", 32'(cfg_bits), 32'(m_cfg));

      // R1: hardware reset restores default and clears redirection
      cfg_read_cmd(1'b0, 1'b0);
      rst_n = 1'b0;
      step();
      m_cfg = 16'h0003; m_act = 1'b0; m_rd = '0;
      check("R1 hw reset cfg", 32'(cfg_bits), 32'h0003);
      check("R1 hw reset rd_word", rd_word, 32'h0);
      rst_n = 1'b1;
      step();
      sweep_reads();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule